// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. It holds four 16-bit segment registers (code, data, stack and extra). These are loaded through a simple write port. Each access request carries an offset and a few attributes: the code of the base register that produced the offset, whether the access is an instruction fetch, whether it is the destination of a string operation, and an optional segment override. From these attributes the block picks which segment register to use.

The selected segment is shifted left by four bits and the offset is added to it. Any carry beyond bit 19 is dropped, so addresses wrap inside the 1 MB space. The result is registered and appears one clock after the request, together with a one-cycle valid strobe. A request that names a byte-half register as its base cannot form an address. It raises a one-cycle error strobe instead of the valid strobe.

Top module: `seg_phys_addr`

## Requirements
- R1: One cycle after a legal request (`reqValid` high), `addrValid` is high for exactly one cycle and `addrOut` equals (selected segment × 16 + offset) mod 2^20. Two different segment:offset pairs that describe the same location (for example 1256:000A and 1240:016A) yield the same address, 1256Ah.
- R2: A carry out of bit 19 is discarded, so segment FFFFh with offset 0010h gives 00000h, and segment FFFFh with offset FFFFh gives 0FFEFh.
- R3: When `isFetch` is high, the code segment is used whatever the values of `baseCode`, `isStrDst` and the override. No error is raised for any `baseCode` value.
- R4: When `isStrDst` is high and `isFetch` is low, the extra segment is used, and any override is ignored.
- R5: For an ordinary access (neither fetch nor string destination, no override), base codes BX=0, SI=1, DI=2 and direct/no-base=7 select the data segment.
- R6: For an ordinary access with no override, base codes BP=3 and SP=4 select the stack segment.
- R7: For an ordinary access with `ovrValid` high, `ovrSel` picks the segment (0 extra, 1 code, 2 stack, 3 data) in place of the default.
- R8: For a non-fetch request with base code BH=5 or BL=6, `addrErr` is high for one cycle, `addrValid` stays low and `addrOut` keeps its previous value.
- R9: Reset clears all four segment registers and drives `addrOut`, `addrValid` and `addrErr` to zero.
- R10: A write with `segWrEn` high stores `segWrData` into the register selected by `segWrSel` (0 extra, 1 code, 2 stack, 3 data) at the clock edge. A request in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write enable |
| segWrSel | input | 2 | Segment register to write: 0 extra, 1 code, 2 stack, 3 data |
| segWrData | input | 16 | Value to write |
| reqValid | input | 1 | Address request strobe |
| offset | input | 16 | Offset within the segment |
| baseCode | input | 3 | Register that supplied the offset: 0 BX, 1 SI, 2 DI, 3 BP, 4 SP, 5 BH, 6 BL, 7 direct |
| isFetch | input | 1 | Request is an instruction fetch |
| isStrDst | input | 1 | Request is a string-operation destination |
| ovrValid | input | 1 | Segment override present |
| ovrSel | input | 2 | Override segment, same encoding as segWrSel |
| addrOut | output | 20 | Registered physical address |
| addrValid | output | 1 | One-cycle strobe: addrOut is new |
| addrErr | output | 1 | One-cycle strobe: request had an illegal base register |

## Verification
The bench targets the priority order among fetch, string destination, override and default. A design that gave the override precedence would move a fetch or a string store into the wrong segment, which shows up as a wrong upper address. Wrap-around is checked at FFFF:0010 and FFFF:FFFF, where a design that kept a 21st bit or saturated would produce a nonzero or clipped address. The byte-half base codes are sent both as ordinary accesses and as fetches. This catches a design that emits a stale valid strobe, updates the address on an error, or wrongly flags fetches. A segment write and a request in the same cycle expose a design that forwards the new value early.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } segSelT;

  typedef enum logic [2:0] {
    BASE_BX     = 3'd0,
    BASE_SI     = 3'd1,
    BASE_DI     = 3'd2,
    BASE_BP     = 3'd3,
    BASE_SP     = 3'd4,
    BASE_BH     = 3'd5,
    BASE_BL     = 3'd6,
    BASE_DIRECT = 3'd7
  } baseCodeT;

  localparam int NumSegs = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   err;
    segSelT segSel;
  } ctrlStrobeT;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] baseCode,
  input  logic       isFetch,
  input  logic       isStrDst,
  input  logic       ovrValid,
  input  logic [1:0] ovrSel,
  output ctrlStrobeT ctrl
);

  logic   illegalBase;
  segSelT defaultSeg;

  always_comb begin
    illegalBase = (baseCode == BASE_BH) || (baseCode == BASE_BL);
    case (baseCode)
      BASE_BP, BASE_SP: defaultSeg = SEG_STACK;
      default:          defaultSeg = SEG_DATA;
    endcase
  end

  always_comb begin
    ctrl.load   = 1'b0;
    ctrl.err    = 1'b0;
    ctrl.segSel = defaultSeg;
    if (isFetch) begin
      ctrl.segSel = SEG_CODE;
      ctrl.load   = reqValid;
    end else if (illegalBase) begin
      ctrl.err = reqValid;
    end else begin
      ctrl.load = reqValid;
      if (isStrDst)      ctrl.segSel = SEG_EXTRA;
      else if (ovrValid) ctrl.segSel = segSelT'(ovrSel);
    end
  end

  always_comb begin
    if (reqValid && isFetch) begin
      p_fetch_code_r3: assert (ctrl.segSel == SEG_CODE && ctrl.load && !ctrl.err);
    end
    if (reqValid && !isFetch && isStrDst && !illegalBase) begin
      p_strdst_extra_r4: assert (ctrl.segSel == SEG_EXTRA);
    end
    if (reqValid && !isFetch && illegalBase) begin
      p_bad_base_r8: assert (ctrl.err && !ctrl.load);
    end
  end

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int SegW  = 16,
  parameter int OffW  = 16,
  parameter int AddrW = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segWrEn,
  input  logic [1:0]       segWrSel,
  input  logic [SegW-1:0]  segWrData,
  input  logic [OffW-1:0]  offset,
  input  ctrlStrobeT       ctrl,
  output logic [AddrW-1:0] addrOut,
  output logic             addrValid,
  output logic             addrErr
);

  localparam int ShiftW = AddrW - SegW;

  logic [SegW-1:0]  segBank [NumSegs];
  logic [SegW-1:0]  segCur;
  logic [AddrW-1:0] physSum;

  for (genvar i = 0; i < NumSegs; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN)                              segBank[i] <= '0;
      else if (segWrEn && (int'(segWrSel) == i)) segBank[i] <= segWrData;
    end
  end

  always_comb begin
    segCur  = segBank[ctrl.segSel];
    physSum = AddrW'({segCur, {ShiftW{1'b0}}}) + AddrW'(offset);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
      addrErr   <= 1'b0;
    end else begin
      addrValid <= ctrl.load;
      addrErr   <= ctrl.err;
      if (ctrl.load) addrOut <= physSum;
    end
  end

  p_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> addrOut == $past(physSum));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && addrErr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> $stable(addrOut));

  p_seg_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    segWrEn |=> segBank[$past(segWrSel)] == $past(segWrData));

endmodule

// File: rtl/seg_phys_addr.sv
module seg_phys_addr
  import seg_pkg::*;
#(
  parameter int SegW  = 16,
  parameter int OffW  = 16,
  parameter int AddrW = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segWrEn,
  input  logic [1:0]       segWrSel,
  input  logic [SegW-1:0]  segWrData,
  input  logic             reqValid,
  input  logic [OffW-1:0]  offset,
  input  logic [2:0]       baseCode,
  input  logic             isFetch,
  input  logic             isStrDst,
  input  logic             ovrValid,
  input  logic [1:0]       ovrSel,
  output logic [AddrW-1:0] addrOut,
  output logic             addrValid,
  output logic             addrErr
);

  ctrlStrobeT ctrl;

  seg_ctrl u_ctrl (
    .reqValid (reqValid),
    .baseCode (baseCode),
    .isFetch  (isFetch),
    .isStrDst (isStrDst),
    .ovrValid (ovrValid),
    .ovrSel   (ovrSel),
    .ctrl     (ctrl)
  );

  seg_datapath #(.SegW(SegW), .OffW(OffW), .AddrW(AddrW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .segWrEn   (segWrEn),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .offset    (offset),
    .ctrl      (ctrl),
    .addrOut   (addrOut),
    .addrValid (addrValid),
    .addrErr   (addrErr)
  );

endmodule

// File: tb/seg_phys_addr_test.sv
module seg_phys_addr_test;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        segWrEn;
  logic [1:0]  segWrSel;
  logic [15:0] segWrData;
  logic        reqValid;
  logic [15:0] offset;
  logic [2:0]  baseCode;
  logic        isFetch, isStrDst, ovrValid;
  logic [1:0]  ovrSel;
  logic [19:0] addrOut;
  logic        addrValid, addrErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  seg_phys_addr uut (.*);

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic idle();
    segWrEn = 0; segWrSel = 0; segWrData = 0; reqValid = 0; offset = 0;
    baseCode = 0; isFetch = 0; isStrDst = 0; ovrValid = 0; ovrSel = 0;
  endtask

  task automatic writeSeg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 0;
  endtask

  // drive one request, outputs visible at the following negedge
  task automatic request(input logic [15:0] off, input logic [2:0] base,
                         input logic fetch, input logic sdst,
                         input logic ov, input logic [1:0] os);
    @(negedge clk);
    reqValid = 1; offset = off; baseCode = base; isFetch = fetch;
    isStrDst = sdst; ovrValid = ov; ovrSel = os;
    @(negedge clk);
    reqValid = 0; isFetch = 0; isStrDst = 0; ovrValid = 0;
  endtask

  task automatic expectAddr(input string tag, input logic [19:0] exp);
    chk({tag, " valid"}, 20'(addrValid), 20'd1);
    chk({tag, " err"}, 20'(addrErr), 20'd0);
    chk({tag, " addr"}, addrOut, exp);
  endtask

  task automatic testReset();
    chk("R9 addrOut", addrOut, 20'h0);
    chk("R9 addrValid", 20'(addrValid), 20'd0);
    chk("R9 addrErr", 20'(addrErr), 20'd0);
    request(16'h1234, 3'd0, 0, 0, 0, 0); expectAddr("R9 data seg zero", 20'h01234);
    request(16'h0042, 3'd3, 0, 0, 0, 0); expectAddr("R9 stack seg zero", 20'h00042);
    @(negedge clk);
    chk("R1 valid one cycle", 20'(addrValid), 20'd0);
  endtask

  task automatic loadSegs();
    writeSeg(2'd0, 16'h1000);
    writeSeg(2'd1, 16'h2000);
    writeSeg(2'd2, 16'h3000);
    writeSeg(2'd3, 16'h4000);
  endtask

  task automatic testFetch();
    request(16'h0010, 3'd3, 1, 1, 1, 2'd2); expectAddr("R3 fetch priority", 20'h20010);
    request(16'h0011, 3'd5, 1, 0, 0, 0);    expectAddr("R3 fetch BH legal", 20'h20011);
  endtask

  task automatic testStrDst();
    request(16'h0020, 3'd2, 0, 1, 1, 2'd1); expectAddr("R4 strdst extra", 20'h10020);
    request(16'h0021, 3'd3, 0, 1, 0, 0);    expectAddr("R4 strdst BP", 20'h10021);
  endtask

  task automatic testDefaults();
    request(16'h0022, 3'd0, 0, 0, 0, 0); expectAddr("R5 BX data", 20'h40022);
    request(16'h0023, 3'd1, 0, 0, 0, 0); expectAddr("R5 SI data", 20'h40023);
    request(16'h0024, 3'd2, 0, 0, 0, 0); expectAddr("R5 DI data", 20'h40024);
    request(16'h0025, 3'd7, 0, 0, 0, 0); expectAddr("R5 direct data", 20'h40025);
    request(16'h0026, 3'd3, 0, 0, 0, 0); expectAddr("R6 BP stack", 20'h30026);
    request(16'h0027, 3'd4, 0, 0, 0, 0); expectAddr("R6 SP stack", 20'h30027);
  endtask

  task automatic testOverride();
    request(16'h0030, 3'd0, 0, 0, 1, 2'd1); expectAddr("R7 BX to code", 20'h20030);
    request(16'h0031, 3'd3, 0, 0, 1, 2'd0); expectAddr("R7 BP to extra", 20'h10031);
    request(16'h0032, 3'd1, 0, 0, 1, 2'd2); expectAddr("R7 SI to stack", 20'h30032);
  endtask

  task automatic testIllegal();
    request(16'h0040, 3'd5, 0, 0, 0, 0);
    chk("R8 BH err", 20'(addrErr), 20'd1);
    chk("R8 BH no valid", 20'(addrValid), 20'd0);
    chk("R8 BH addr held", addrOut, 20'h30032);
    request(16'h0041, 3'd6, 0, 0, 1, 2'd1);
    chk("R8 BL err", 20'(addrErr), 20'd1);
    chk("R8 BL no valid", 20'(addrValid), 20'd0);
    chk("R8 BL addr held", addrOut, 20'h30032);
    @(negedge clk);
    chk("R8 err one cycle", 20'(addrErr), 20'd0);
  endtask

  task automatic testWrap();
    writeSeg(2'd3, 16'hFFFF);
    request(16'h0010, 3'd0, 0, 0, 0, 0); expectAddr("R2 wrap to zero", 20'h00000);
    request(16'hFFFF, 3'd0, 0, 0, 0, 0); expectAddr("R2 wrap max", 20'h0FFEF);
  endtask

  task automatic testAlias();
    writeSeg(2'd3, 16'h1256);
    request(16'h000A, 3'd0, 0, 0, 0, 0); expectAddr("R1 alias a", 20'h1256A);
    writeSeg(2'd3, 16'h1240);
    request(16'h016A, 3'd0, 0, 0, 0, 0); expectAddr("R1 alias b", 20'h1256A);
  endtask

  task automatic testWriteCollision();
    @(negedge clk);
    segWrEn = 1; segWrSel = 2'd3; segWrData = 16'h5000;
    reqValid = 1; offset = 16'h0001; baseCode = 3'd0;
    @(negedge clk);
    segWrEn = 0; reqValid = 0;
    expectAddr("R10 old value same cycle", 20'h12401);
    request(16'h0001, 3'd0, 0, 0, 0, 0); expectAddr("R10 new value", 20'h50001);
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    loadSegs();
    testFetch();
    testStrDst();
    testDefaults();
    testOverride();
    testIllegal();
    testWrap();
    testAlias();
    testWriteCollision();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule